// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Non-Maskable Class

This block decides which interrupt request a small 8-bit CPU core takes next, and it paces the entry into the handler. Each request line has an enable input. A build-time mask puts each line in the urgent (non-maskable) class or the regular class. Regular lines are gated by the core's global interrupt-enable flag. Urgent lines are not gated by that flag. When several eligible requests are pending together, the lowest line index wins. The lowest index is also the lowest vector address.

Once a winner is latched, the sequencer waits for the core's instruction-complete strobe. It then spends two cycles pushing the program counter, low half first and then high half. After that it holds the handler vector for three jump cycles. On the first push cycle it emits an acknowledge with the winning line index, so that the requester can drop its flag. For a regular winner it also asks the core to clear the global enable flag. An urgent entry leaves that flag alone. It also marks an urgent handler as active, and while that mark is set no further entry is started. The handler-return strobe clears the mark, and arbitration then resumes.

The reset input is asynchronous and active low, and it is released through a two-stage synchronizer.

Top module: `intr_sequencer`

## Requirements
- R1: A pending, enabled line whose bit in URGENT_MASK is 1 is taken even when gie_i is 0.
- R2: A line whose en_i bit is 0 is never taken, whatever its class or the state of gie_i.
- R3: A line whose URGENT_MASK bit is 0 is taken only when gie_i is 1. gie_clr_o pulses for one cycle together with ack_o for a regular winner, and it stays 0 for an urgent winner.
- R4: Among the eligible pending lines, the one with the lowest index wins.
- R5: busy_o rises on the clock edge after a winner is present. push_o is 1 for exactly the two cycles after the edge that samples instr_done_i high while busy. push_data_o carries pc_i[PC_W/2-1:0] in the first cycle and pc_i[PC_W-1:PC_W/2] in the second, both taken from the value of pc_i that was sampled with instr_done_i.
- R6: While the sequencer is waiting and instr_done_i is 0, no push begins, however long the wait lasts.
- R7: Right after the second push cycle, jump_o is 1 for exactly JUMP_CYC cycles (default 3). During those cycles vec_o equals VEC_BASE + index*VEC_STEP. Then busy_o returns to 0.
- R8: ack_o is a one-cycle pulse that coincides with the first push cycle. ack_id_o then holds the winning index.
- R9: urgent_act_o goes to 1 in the first push cycle of an urgent entry. While it is 1 and ret_i is 0, no new entry starts.
- R10: ret_i clears urgent_act_o on the next edge. A request still pending is then arbitrated, and busy_o rises one edge after the clearing edge.
- R11: After reset, busy_o, push_o, ack_o, gie_clr_o, jump_o and urgent_act_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_LINES | Pending request flags, one per line |
| en_i | input | N_LINES | Per-line enable |
| gie_i | input | 1 | Global interrupt-enable flag of the core |
| instr_done_i | input | 1 | Current instruction completes this cycle |
| ret_i | input | 1 | Handler-return strobe |
| pc_i | input | PC_W | Program counter to be saved |
| busy_o | output | 1 | Entry sequence in progress |
| push_o | output | 1 | Stack write strobe |
| push_data_o | output | PC_W/2 | Half of the program counter being pushed |
| ack_o | output | 1 | Acknowledge pulse to the winning requester |
| ack_id_o | output | ID_W | Winning line index during ack_o |
| gie_clr_o | output | 1 | Request to clear the global enable flag |
| jump_o | output | 1 | Vector jump in progress |
| vec_o | output | PC_W | Handler vector address during jump_o |
| urgent_act_o | output | 1 | An urgent-class handler is being serviced |

## Verification
The handler-return strobe and a pending request can arrive in the same cycle as each other. The return clears the urgent-active mark, and the request wants to start an entry. The bench first takes an urgent line so that the mark is set. It then holds both an urgent and a regular request for several cycles to confirm that nothing starts. Next it pulses ret_i while those requests are still held. The check requires that no entry starts on the edge that clears the mark, that busy_o rises on the following edge, and that the acknowledge names the lower-index winner.

// File: rtl/intr_pkg.sv
package intr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FINISH  = 3'd1,
    ST_PUSH_LO = 3'd2,
    ST_PUSH_HI = 3'd3,
    ST_JUMP    = 3'd4
  } entry_st_t;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/intr_elig.sv
module intr_elig #(
  parameter int unsigned           N_LINES     = 8,
  parameter logic [N_LINES-1:0]    URGENT_MASK = '0
) (
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] en_i,
  input  logic               gie_i,
  input  logic               urgent_act_i,
  output logic [N_LINES-1:0] elig_o
);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    if (URGENT_MASK[g]) begin : g_urgent
      assign elig_o[g] = req_i[g] & en_i[g] & ~urgent_act_i;
    end else begin : g_regular
      assign elig_o[g] = req_i[g] & en_i[g] & gie_i & ~urgent_act_i;
    end
  end

endmodule

// File: rtl/intr_pick.sv
module intr_pick #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned ID_W    = 3
) (
  input  logic [N_LINES-1:0] elig_i,
  output logic               found_o,
  output logic [ID_W-1:0]    id_o
);

  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/intr_entry_fsm.sv
module intr_entry_fsm
  import intr_pkg::*;
#(
  parameter int unsigned ID_W     = 3,
  parameter int unsigned PC_W     = 16,
  parameter int unsigned JUMP_CYC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            found_i,
  input  logic [ID_W-1:0] pick_id_i,
  input  logic            pick_urgent_i,
  input  logic            instr_done_i,
  input  logic [PC_W-1:0] pc_i,
  output entry_st_t       state_o,
  output logic [ID_W-1:0] win_id_o,
  output logic            win_urgent_o,
  output logic [PC_W-1:0] pc_hold_o,
  output logic            take_o
);

  localparam int unsigned CNT_W = (JUMP_CYC > 1) ? $clog2(JUMP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(JUMP_CYC - 1);

  entry_st_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ID_W-1:0]  id_q;
  logic             urg_q;
  logic [PC_W-1:0]  pc_q;
  logic             latch_en;

  assign latch_en = (st_q == ST_IDLE) && found_i;
  assign take_o   = (st_q == ST_FINISH) && instr_done_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:    if (found_i) st_d = ST_FINISH;
      ST_FINISH:  if (instr_done_i) st_d = ST_PUSH_LO;
      ST_PUSH_LO: st_d = ST_PUSH_HI;
      ST_PUSH_HI: begin
        st_d  = ST_JUMP;
        cnt_d = '0;
      end
      ST_JUMP: begin
        if (cnt_q == CNT_LAST) st_d = ST_IDLE;
        else                   cnt_d = cnt_q + 1'b1;
      end
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= '0;
      urg_q <= 1'b0;
    end else if (latch_en) begin
      id_q  <= pick_id_i;
      urg_q <= pick_urgent_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (take_o) begin
      pc_q <= pc_i;
    end
  end

  assign state_o      = st_q;
  assign win_id_o     = id_q;
  assign win_urgent_o = urg_q;
  assign pc_hold_o    = pc_q;

endmodule

// File: rtl/intr_level_track.sv
module intr_level_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic active_o
);

  logic act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (set_i)      act_d = 1'b1;
    else if (clr_i) act_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_d;
  end

  assign active_o = act_q;

endmodule

// File: rtl/intr_sequencer.sv
module intr_sequencer
  import intr_pkg::*;
#(
  parameter int unsigned        N_LINES     = 8,
  parameter logic [N_LINES-1:0] URGENT_MASK = N_LINES'(3),
  parameter int unsigned        PC_W        = 16,
  parameter logic [PC_W-1:0]    VEC_BASE    = PC_W'(4),
  parameter int unsigned        VEC_STEP    = 4,
  parameter int unsigned        JUMP_CYC    = 3,
  localparam int unsigned       ID_W        = idx_width(N_LINES),
  localparam int unsigned       HALF_W      = PC_W / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] en_i,
  input  logic               gie_i,
  input  logic               instr_done_i,
  input  logic               ret_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic               busy_o,
  output logic               push_o,
  output logic [HALF_W-1:0]  push_data_o,
  output logic               ack_o,
  output logic [ID_W-1:0]    ack_id_o,
  output logic               gie_clr_o,
  output logic               jump_o,
  output logic [PC_W-1:0]    vec_o,
  output logic               urgent_act_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [N_LINES-1:0] elig;
  logic               found;
  logic [ID_W-1:0]    pick_id;
  logic               pick_urgent;
  entry_st_t          state;
  logic [ID_W-1:0]    win_id;
  logic               win_urgent;
  logic [PC_W-1:0]    pc_hold;
  logic               take;
  logic               urgent_act;

  intr_elig #(
    .N_LINES     (N_LINES),
    .URGENT_MASK (URGENT_MASK)
  ) elig_i (
    .req_i        (req_i),
    .en_i         (en_i),
    .gie_i        (gie_i),
    .urgent_act_i (urgent_act),
    .elig_o       (elig)
  );

  intr_pick #(
    .N_LINES (N_LINES),
    .ID_W    (ID_W)
  ) pick_i (
    .elig_i  (elig),
    .found_o (found),
    .id_o    (pick_id)
  );

  assign pick_urgent = URGENT_MASK[pick_id];

  intr_entry_fsm #(
    .ID_W     (ID_W),
    .PC_W     (PC_W),
    .JUMP_CYC (JUMP_CYC)
  ) fsm_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_s),
    .found_i       (found),
    .pick_id_i     (pick_id),
    .pick_urgent_i (pick_urgent),
    .instr_done_i  (instr_done_i),
    .pc_i          (pc_i),
    .state_o       (state),
    .win_id_o      (win_id),
    .win_urgent_o  (win_urgent),
    .pc_hold_o     (pc_hold),
    .take_o        (take)
  );

  intr_level_track lvl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .set_i    (take & win_urgent),
    .clr_i    (ret_i),
    .active_o (urgent_act)
  );

  logic in_lo, in_hi, in_jump;
  assign in_lo   = (state == ST_PUSH_LO);
  assign in_hi   = (state == ST_PUSH_HI);
  assign in_jump = (state == ST_JUMP);

  always_comb begin
    push_data_o = '0;
    if (in_lo)      push_data_o = pc_hold[HALF_W-1:0];
    else if (in_hi) push_data_o = pc_hold[PC_W-1:HALF_W];
  end

  assign busy_o       = (state != ST_IDLE);
  assign push_o       = in_lo | in_hi;
  assign ack_o        = in_lo;
  assign ack_id_o     = in_lo ? win_id : '0;
  assign gie_clr_o    = in_lo & ~win_urgent;
  assign jump_o       = in_jump;
  assign vec_o        = in_jump ? (VEC_BASE + PC_W'(win_id) * PC_W'(VEC_STEP)) : '0;
  assign urgent_act_o = urgent_act;

endmodule

// File: rtl/intr_sequencer_chk.sv
module intr_sequencer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic push_o,
  input logic ack_o,
  input logic gie_clr_o,
  input logic jump_o,
  input logic urgent_act_o,
  input logic instr_done_i,
  input logic ret_i
);

  // R3: the flag-clear request only comes with an acknowledge, and never during urgent service
  p_clr_regular_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_o |-> (ack_o && !urgent_act_o));

  // R5: a push always lasts two cycles
  p_push_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(push_o) |=> push_o);

  // R6: no push starts while waiting without the completion strobe
  p_wait_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !push_o && !jump_o && !instr_done_i) |=> !push_o);

  // R7: the jump follows the second push cycle and lasts three cycles
  p_push_to_jump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && $past(push_o)) |=> (jump_o && !push_o));

  p_jump_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jump_o) |=> jump_o ##1 jump_o ##1 !jump_o);

  // R8: the acknowledge marks the first push cycle
  p_ack_first_push_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (push_o && $rose(push_o)));

  // R9: urgent service blocks any new entry
  p_urgent_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urgent_act_o && !busy_o && !ret_i) |=> !busy_o);

  // R10: the return strobe clears urgent service when no entry is underway
  p_ret_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !busy_o) |=> !urgent_act_o);

endmodule

bind intr_sequencer intr_sequencer_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .push_o       (push_o),
  .ack_o        (ack_o),
  .gie_clr_o    (gie_clr_o),
  .jump_o       (jump_o),
  .urgent_act_o (urgent_act_o),
  .instr_done_i (instr_done_i),
  .ret_i        (ret_i)
);

// File: tb/intr_sequencer_tb_top.sv
module intr_sequencer_tb_top;

  localparam int unsigned N   = 4;
  localparam logic [3:0]  URG = 4'b0101;
  localparam int unsigned PCW = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [3:0]  req_i, en_i;
  logic        gie_i, instr_done_i, ret_i;
  logic [15:0] pc_i;
  logic        busy_o, push_o, ack_o, gie_clr_o, jump_o, urgent_act_o;
  logic [7:0]  push_data_o;
  logic [1:0]  ack_id_o;
  logic [15:0] vec_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  intr_sequencer #(
    .N_LINES     (N),
    .URGENT_MASK (URG),
    .PC_W        (PCW),
    .VEC_BASE    (16'h0004),
    .VEC_STEP    (4),
    .JUMP_CYC    (3)
  ) dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int winner(input logic [3:0] r, input logic [3:0] e, input logic g);
    for (int i = 0; i < 4; i++)
      if (r[i] && e[i] && (URG[i] || g)) return i;
    return -1;
  endfunction

  task automatic step();
    @(negedge clk_i);
  endtask

  // From the latched-winner cycle (FINISH, instr_done_i already 1) through the jump
  task automatic run_entry(input int w, input logic [15:0] pc, input string tag);
    step();
    chk({tag, " R5 push lo"}, push_o, 1);
    chk({tag, " R5 data lo"}, push_data_o, pc[7:0]);
    chk({tag, " R8 ack"}, ack_o, 1);
    chk({tag, " R8 ack id"}, ack_id_o, w);
    chk({tag, " R3 gie clr"}, gie_clr_o, URG[w] ? 0 : 1);
    chk({tag, " R9 urgent act"}, urgent_act_o, URG[w]);
    req_i = '0;
    instr_done_i = 1'b0;
    step();
    chk({tag, " R5 push hi"}, push_o, 1);
    chk({tag, " R5 data hi"}, push_data_o, pc[15:8]);
    chk({tag, " R8 ack off"}, ack_o, 0);
    for (int j = 0; j < 3; j++) begin
      step();
      chk({tag, " R7 jump"}, jump_o, 1);
      chk({tag, " R7 vec"}, vec_o, 4 + 4 * w);
      chk({tag, " R7 push off"}, push_o, 0);
    end
    step();
    chk({tag, " R7 end jump"}, jump_o, 0);
    chk({tag, " R7 idle"}, busy_o, 0);
  endtask

  initial begin
    rst_ni = 1'b0;
    req_i = '0; en_i = '0; gie_i = 1'b0; instr_done_i = 1'b0; ret_i = 1'b0; pc_i = '0;
    repeat (3) step();
    rst_ni = 1'b1;
    repeat (3) step();
    chk("R11 busy", busy_o, 0);
    chk("R11 push", push_o, 0);
    chk("R11 ack", ack_o, 0);
    chk("R11 gie clr", gie_clr_o, 0);
    chk("R11 jump", jump_o, 0);
    chk("R11 urgent", urgent_act_o, 0);

    // Sweep over every request, enable and global-flag combination
    for (int k = 0; k < 512; k++) begin
      int w;
      logic [15:0] pc;
      req_i = k[3:0];
      en_i  = k[7:4];
      gie_i = k[8];
      instr_done_i = 1'b1;
      pc = 16'hA5C3 ^ 16'(k * 37);
      pc_i = pc;
      w = winner(k[3:0], k[7:4], k[8]);
      step();
      if (w < 0) begin
        chk("R1 R2 R3 no entry", busy_o, 0);
        req_i = '0;
        step();
        chk("R2 R3 still idle", busy_o, 0);
      end else begin
        chk("R4 R1 busy rises", busy_o, 1);
        chk("R5 finish no push", push_o, 0);
        run_entry(w, pc, "R4 sweep");
        ret_i = 1'b1;
        step();
        ret_i = 1'b0;
        chk("R10 ret clears", urgent_act_o, 0);
      end
    end

    // R6: long wait for the instruction to complete
    gie_i = 1'b1; en_i = 4'hF; req_i = 4'b0010; instr_done_i = 1'b0; pc_i = 16'h1357;
    step();
    chk("R6 busy", busy_o, 1);
    for (int j = 0; j < 6; j++) begin
      step();
      chk("R6 waiting no push", push_o, 0);
      chk("R6 still busy", busy_o, 1);
    end
    instr_done_i = 1'b1;
    run_entry(1, 16'h1357, "R6 delayed");

    // R9 / R10: urgent service blocks, then the return coincides with pending requests
    req_i = 4'b0001; instr_done_i = 1'b1; pc_i = 16'h2468;
    step();
    chk("R1 urgent busy", busy_o, 1);
    run_entry(0, 16'h2468, "R9 urgent");
    chk("R9 act held", urgent_act_o, 1);
    req_i = 4'b0110; gie_i = 1'b1; instr_done_i = 1'b1; pc_i = 16'h0F0F;
    for (int j = 0; j < 4; j++) begin
      step();
      chk("R9 blocked", busy_o, 0);
    end
    ret_i = 1'b1;
    step();
    ret_i = 1'b0;
    chk("R10 no start on clearing edge", busy_o, 0);
    chk("R10 act cleared", urgent_act_o, 0);
    step();
    chk("R10 start next edge", busy_o, 1);
    run_entry(1, 16'h0F0F, "R10 resume");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule